// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block is the alarm section of a real-time clock. It keeps one alarm register for each calendar field (seconds, minutes, hours, weekday, day of month, month, year), each with its own enable. Whenever the seconds counter advances, the block compares every enabled alarm value with the matching live BCD counter. When all enabled fields agree, it raises a sticky alarm flag. The flag drives an interrupt line until software clears it.

The live counters and a one-cycle seconds-update strobe come in from the timekeeping logic. Software uses a small register bus: a 3-bit address, 8-bit write data, a write strobe and combinational read data. The block has a synchronous reset. A reset-kind input marks a reset as power-on or deep-standby. Only that kind of reset clears the enables. Alarm values are never reset.

The flag is a two-state machine. FLAG_IDLE moves to FLAG_RAISED on a seconds strobe while the match is true (transition "raise"). FLAG_RAISED returns to FLAG_IDLE when software writes 0 to the flag bit with no concurrent raise condition (transition "clear"). Any reset forces FLAG_IDLE (transition "reset"). Every other case holds the present state.

Top module: `alarm_match_unit`

## Requirements
- R1: A field takes part in the comparison only when its enable is 1. Enables sit in bit 7 of alarm registers 0–5. The year enable sits in bit 7 of the control register at address 7. A disabled field's counter value has no effect on the flag.
- R2: The flag is set when a seconds strobe cycle sees every enabled field equal to its counter. Seconds, minutes, hours, day of month and month compare value bits 6:0. Year compares bits 7:0. The flag reads 1 from the cycle after the strobe.
- R3: With no field enabled, the flag is never set.
- R4: Once set, the flag stays 1 until a write to address 7 with bit 0 = 0. A write with bit 0 = 1 has no effect. If a clear write and a raise condition fall in the same cycle, the flag stays 1.
- R5: The weekday alarm (address 3) holds a 3-bit code in bits 2:0, with 0 = Sunday through 6 = Saturday. Bits 6:3 read as 0 whatever was written.
- R6: A reset with rst_full_i = 1 clears every enable. A reset with rst_full_i = 0 keeps every enable.
- R7: Alarm value bits keep their contents through every kind of reset.
- R8: Any reset clears the flag. alarm_irq_o equals the flag.
- R9: Without a seconds strobe, a matching state never sets the flag.
- R10: The register map is: addresses 0–6 hold seconds, minutes, hours, weekday, day of month, month and year. Address 7 is the control register. Its bit 0 is the flag, its bit 7 is the year enable, and its bits 6:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| rst_full_i | input | 1 | Reset kind: 1 = power-on or deep standby |
| sec_tick_i | input | 1 | One-cycle strobe when the seconds counter updates |
| cnt_sec_i | input | 8 | Live BCD seconds |
| cnt_min_i | input | 8 | Live BCD minutes |
| cnt_hour_i | input | 8 | Live BCD hours |
| cnt_wday_i | input | 3 | Live weekday code |
| cnt_mday_i | input | 8 | Live BCD day of month |
| cnt_mon_i | input | 8 | Live BCD month |
| cnt_year_i | input | 8 | Live BCD year |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| alarm_irq_o | output | 1 | Alarm interrupt, equal to the flag |

## Verification
If the flag state machine is in the wrong state, the fault shows on alarm_irq_o and control bit 0 one cycle after the strobe or write that caused it. The state also stays wrong, so a later read finds it. A wrong enable or stored value only appears at the next seconds strobe, as a missed or spurious alarm. It can also be read back directly, which catches it at once. Reset-kind mistakes are exposed by reading the registers right after each kind of reset.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
    localparam int NUM_FIELDS = 7;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int WDAY_IDX   = 3;
    localparam int YEAR_IDX   = 6;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(7);

    typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] field_vec_t;

    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

    // Bits of a stored alarm value that are kept and compared per field.
    function automatic logic [DATA_W-1:0] value_mask(input int idx);
        if (idx == WDAY_IDX)      return DATA_W'(8'h07);
        else if (idx == YEAR_IDX) return DATA_W'(8'hFF);
        else                      return DATA_W'(8'h7F);
    endfunction

    // Address whose bit 7 carries a field's enable.
    function automatic logic [ADDR_W-1:0] enable_addr(input int idx);
        if (idx == YEAR_IDX) return CTRL_ADDR;
        else                 return ADDR_W'(idx);
    endfunction
endpackage

// File: rtl/alarm_reg_bank.sv
module alarm_reg_bank
    import alarm_match_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_n_i,
    input  logic                  rst_full_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    input  logic                  bus_we_i,
    input  logic                  flag_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    output field_vec_t            val_o,
    output logic [NUM_FIELDS-1:0] en_o
);
    field_vec_t            val_q;
    logic [NUM_FIELDS-1:0] en_q;

    // Value bits: no reset of any kind.
    always_ff @(posedge clk_i) begin
        for (int k = 0; k < NUM_FIELDS; k++) begin
            if (bus_we_i && bus_addr_i == ADDR_W'(k))
                val_q[k] <= bus_wdata_i & value_mask(k);
        end
    end

    // Enable bits: cleared only by the full reset kind.
    always_ff @(posedge clk_i) begin
        for (int k = 0; k < NUM_FIELDS; k++) begin
            if (!rst_n_i) begin
                if (rst_full_i) en_q[k] <= 1'b0;
            end else if (bus_we_i && bus_addr_i == enable_addr(k)) begin
                en_q[k] <= bus_wdata_i[DATA_W-1];
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == CTRL_ADDR) begin
            bus_rdata_o = {en_q[YEAR_IDX], {(DATA_W-2){1'b0}}, flag_i};
        end else if (bus_addr_i == ADDR_W'(YEAR_IDX)) begin
            bus_rdata_o = val_q[YEAR_IDX];
        end else begin
            for (int k = 0; k < NUM_FIELDS; k++) begin
                if (k != YEAR_IDX && bus_addr_i == ADDR_W'(k))
                    bus_rdata_o = {en_q[k], val_q[k][DATA_W-2:0]};
            end
        end
    end

    assign val_o = val_q;
    assign en_o  = en_q;

    assert_full_reset_clears_R6: assert property (@(posedge clk_i)
        (!rst_n_i && rst_full_i) |=> (en_q == '0));

    assert_wday_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (bus_addr_i == ADDR_W'(WDAY_IDX)) |-> (bus_rdata_o[6:3] == 4'b0));
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
    import alarm_match_pkg::*;
(
    input  field_vec_t            val_i,
    input  logic [NUM_FIELDS-1:0] en_i,
    input  field_vec_t            cnt_i,
    output logic                  match_o
);
    logic [NUM_FIELDS-1:0] hit;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        localparam logic [DATA_W-1:0] MASK = value_mask(g);
        assign hit[g] = !en_i[g] || ((val_i[g] & MASK) == (cnt_i[g] & MASK));
    end

    assign match_o = (|en_i) && (&hit);
endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm
    import alarm_match_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic tick_i,
    input  logic match_i,
    input  logic clr_req_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (tick_i && match_i) state_d = FLAG_RAISED;
            FLAG_RAISED: if (clr_req_i && !(tick_i && match_i)) state_d = FLAG_IDLE;
            default:     state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_q <= FLAG_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLAG_RAISED: flag_o = 1'b1;
            default:     flag_o = 1'b0;
        endcase
    end

    assert_rise_needs_match_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(flag_o) |-> $past(tick_i && match_i));

    assert_sticky_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (flag_o && !clr_req_i) |=> flag_o);

    assert_clear_works_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clr_req_i && !(tick_i && match_i)) |=> !flag_o);

    assert_no_tick_no_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!flag_o && !tick_i) |=> !flag_o);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_match_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              rst_full_i,
    input  logic              sec_tick_i,
    input  logic [7:0]        cnt_sec_i,
    input  logic [7:0]        cnt_min_i,
    input  logic [7:0]        cnt_hour_i,
    input  logic [2:0]        cnt_wday_i,
    input  logic [7:0]        cnt_mday_i,
    input  logic [7:0]        cnt_mon_i,
    input  logic [7:0]        cnt_year_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              alarm_irq_o
);
    field_vec_t            cnt_vec;
    field_vec_t            val_vec;
    logic [NUM_FIELDS-1:0] en_vec;
    logic                  match;
    logic                  flag;
    logic                  clr_req;

    assign cnt_vec[0]        = cnt_sec_i;
    assign cnt_vec[1]        = cnt_min_i;
    assign cnt_vec[2]        = cnt_hour_i;
    assign cnt_vec[WDAY_IDX] = {5'b0, cnt_wday_i};
    assign cnt_vec[4]        = cnt_mday_i;
    assign cnt_vec[5]        = cnt_mon_i;
    assign cnt_vec[YEAR_IDX] = cnt_year_i;

    assign clr_req = bus_we_i && (bus_addr_i == CTRL_ADDR) && !bus_wdata_i[0];

    alarm_reg_bank u_regs (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .rst_full_i  (rst_full_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_we_i    (bus_we_i),
        .flag_i      (flag),
        .bus_rdata_o (bus_rdata_o),
        .val_o       (val_vec),
        .en_o        (en_vec)
    );

    alarm_compare u_cmp (
        .val_i   (val_vec),
        .en_i    (en_vec),
        .cnt_i   (cnt_vec),
        .match_o (match)
    );

    alarm_flag_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .tick_i    (sec_tick_i),
        .match_i   (match),
        .clr_req_i (clr_req),
        .flag_o    (flag)
    );

    assign alarm_irq_o = flag;

    assert_none_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ((en_vec == '0) && !flag) |=> !flag);

    assert_reset_drops_flag_R8: assert property (@(posedge clk_i)
        !rst_n_i |=> !alarm_irq_o);
endmodule

// File: tb/alarm_match_unit_tb_top.sv
`timescale 1ns/1ps
module alarm_match_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_full = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] c_sec = 8'h00, c_min = 8'h00, c_hour = 8'h00;
    logic [2:0] c_wday = 3'd0;
    logic [7:0] c_mday = 8'h01, c_mon = 8'h01, c_year = 8'h00;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic       we = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        logic       exp_irq;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    alarm_match_unit dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .rst_full_i(rst_full), .sec_tick_i(tick),
        .cnt_sec_i(c_sec), .cnt_min_i(c_min), .cnt_hour_i(c_hour), .cnt_wday_i(c_wday),
        .cnt_mday_i(c_mday), .cnt_mon_i(c_mon), .cnt_year_i(c_year),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we),
        .bus_rdata_o(rdata), .alarm_irq_o(irq)
    );

    // Monitor: pops one expected item per falling edge and compares.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            total++;
            if (((rdata & it.mask) !== (it.exp & it.mask)) || (irq !== it.exp_irq)) begin
                bad++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b (mask %h)",
                         it.tag, rdata, irq, it.exp, it.exp_irq, it.mask);
            end
        end
    end

    task automatic expect_rd(input logic [2:0] a, input logic [7:0] mask,
                             input logic [7:0] exp, input logic exp_irq, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        addr = a;
        it.exp = exp; it.mask = mask; it.exp_irq = exp_irq; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic pulse_tick();
        @(posedge clk); #1;
        tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    task automatic do_reset(input logic full);
        @(posedge clk); #1;
        rst_n = 1'b0; rst_full = full;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1; rst_full = 1'b0;
    endtask

    task automatic set_match_counters();
        @(posedge clk); #1;
        c_sec = 8'h30; c_min = 8'h15; c_hour = 8'h12; c_wday = 3'd3;
        c_mday = 8'h21; c_mon = 8'h09; c_year = 8'h24;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1; rst_full = 1'b0;

        expect_rd(3'd7, 8'hFF, 8'h00, 1'b0, "R8 ctrl after power-on reset");
        expect_rd(3'd0, 8'h80, 8'h00, 1'b0, "R6 seconds enable cleared at power-on");

        wr(3'd0, 8'h30); wr(3'd1, 8'h15); wr(3'd2, 8'h12); wr(3'd3, 8'h7B);
        wr(3'd4, 8'h21); wr(3'd5, 8'h09); wr(3'd6, 8'h24);
        expect_rd(3'd3, 8'hFF, 8'h03, 1'b0, "R5 weekday reserved bits read zero");
        expect_rd(3'd6, 8'hFF, 8'h24, 1'b0, "R10 year value readback");
        expect_rd(3'd1, 8'hFF, 8'h15, 1'b0, "R10 minutes readback");

        set_match_counters();
        pulse_tick();
        expect_rd(3'd7, 8'hFF, 8'h00, 1'b0, "R3 no enabled field gives no alarm");

        wr(3'd0, 8'hB0);
        @(posedge clk); #1; c_sec = 8'h31;
        pulse_tick();
        expect_rd(3'd7, 8'hFF, 8'h00, 1'b0, "R1 enabled seconds mismatch");
        @(posedge clk); #1; c_sec = 8'h30;
        repeat (4) @(posedge clk);
        expect_rd(3'd7, 8'hFF, 8'h00, 1'b0, "R9 match without strobe");
        pulse_tick();
        expect_rd(3'd7, 8'hFF, 8'h01, 1'b1, "R2 seconds match raises flag");

        @(posedge clk); #1; c_sec = 8'h45;
        pulse_tick();
        expect_rd(3'd7, 8'hFF, 8'h01, 1'b1, "R4 flag sticky after counters move");
        wr(3'd7, 8'h01);
        expect_rd(3'd7, 8'hFF, 8'h01, 1'b1, "R4 writing one leaves flag");
        wr(3'd7, 8'h00);
        expect_rd(3'd7, 8'hFF, 8'h00, 1'b0, "R4 writing zero clears flag");

        wr(3'd1, 8'h95); wr(3'd3, 8'h83);
        expect_rd(3'd3, 8'hFF, 8'h83, 1'b0, "R5 weekday enable and code readback");
        @(posedge clk); #1; c_sec = 8'h30; c_min = 8'h16;
        pulse_tick();
        expect_rd(3'd7, 8'hFF, 8'h00, 1'b0, "R1 one enabled field differs");
        @(posedge clk); #1; c_min = 8'h15; c_mday = 8'h05;
        pulse_tick();
        expect_rd(3'd7, 8'hFF, 8'h01, 1'b1, "R1 disabled day-of-month ignored");
        wr(3'd7, 8'h00);

        wr(3'd7, 8'h80);
        @(posedge clk); #1; c_year = 8'h25;
        pulse_tick();
        expect_rd(3'd7, 8'hFF, 8'h80, 1'b0, "R10 year enable in ctrl bit 7 mismatch");
        @(posedge clk); #1; c_year = 8'h24;
        pulse_tick();
        expect_rd(3'd7, 8'hFF, 8'h81, 1'b1, "R2 year joins match");

        // Clear write and raise in the same cycle: raise wins.
        @(posedge clk); #1;
        addr = 3'd7; wdata = 8'h80; we = 1'b1; tick = 1'b1;
        @(posedge clk); #1;
        we = 1'b0; tick = 1'b0;
        expect_rd(3'd7, 8'hFF, 8'h81, 1'b1, "R4 raise beats concurrent clear");
        wr(3'd7, 8'h80);
        expect_rd(3'd7, 8'hFF, 8'h80, 1'b0, "R4 clear afterwards");
        pulse_tick();
        expect_rd(3'd7, 8'hFF, 8'h81, 1'b1, "R8 flag set before manual reset");

        do_reset(1'b0);
        expect_rd(3'd7, 8'hFF, 8'h80, 1'b0, "R8 manual reset clears flag keeps year enable");
        expect_rd(3'd0, 8'hFF, 8'hB0, 1'b0, "R6 manual reset keeps seconds enable");
        expect_rd(3'd4, 8'hFF, 8'h21, 1'b0, "R7 value kept across manual reset");

        do_reset(1'b1);
        expect_rd(3'd0, 8'hFF, 8'h30, 1'b0, "R7 seconds value kept, enable cleared");
        expect_rd(3'd3, 8'hFF, 8'h03, 1'b0, "R6 weekday enable cleared");
        expect_rd(3'd7, 8'hFF, 8'h00, 1'b0, "R6 year enable cleared");
        pulse_tick();
        expect_rd(3'd7, 8'hFF, 8'h00, 1'b0, "R3 no alarm after full reset");

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule